// File: doc/BRIEF.md
# Reserving Load and Conditional Store Unit

This unit sits between a simple 32-bit core and a single-port word memory. It carries out plain word loads and stores, plus one atomic pair: a reserving load that remembers where it read and what it saw, and a conditional store that writes only if that reservation is still good. The core presents one command at a time: an opcode, a base register value, a 16-bit offset and store data. The unit forms the address, runs the memory handshake and reports completion with a one-cycle `done` pulse. A load returns its word on `rdata`. A conditional store returns pass or fail on `flag`.

A conditional store passes only under two conditions. Its address must equal the reserved address, and a fresh read of that word must still return the value captured by the reserving load. No snooping is needed, because a plain store that changed the word in the meantime is caught by this second read. Every conditional store drops the reservation, whether it passes or fails, and so does the `exc_in` input. The reservation has its own valid bit. An invalidated reservation also parks its address at all ones, and that parked address never counts as a match.

Command handshake rules: a command is transferred on a clock edge where both `cmd_valid` and `cmd_ready` are high. The core holds the fields stable until that edge. `cmd_ready` is high only while the unit is idle. Memory handshake rules: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` held stable, until a cycle in which `mem_ready` is high. Read data on `mem_rdata` is taken in that same cycle. The response has no back-pressure: `done` is a single-cycle pulse.

Top module: `lrsc_unit`

## Requirements
- R1: The memory address is the base value plus the 16-bit offset sign-extended to 32 bits. For example, base 0x20 with offset 0xFFFC addresses 0x1C.
- R2: Opcode 0x1b is the reserving load. It reads one word, returns it on `rdata` and records the address and the word as the reservation. Opcode 0x21 is a plain load. It returns the word the same way and leaves the reservation alone. With memory wait W, `done` comes W+1 cycles after the accept edge.
- R3: Opcode 0x35 is a plain store. It writes `cmd_wdata` to the word, with `done` W+1 cycles after acceptance.
- R4: Opcode 0x33 is the conditional store. When no reservation is valid, or its address differs from the reserved address, it fails: `flag` becomes 0 and `done` rises right after the accept edge. It makes no memory access.
- R5: If the conditional store's address matches, the unit reads the word again. If that word differs from the recorded value, the store fails with `flag` 0 after the one read, and no write is issued.
- R6: If the re-read word equals the recorded value, the unit writes the store data and sets `flag` to 1. `done` comes 2W+2 cycles after acceptance. `flag` changes only together with `done`.
- R7: Every conditional store invalidates the reservation, so a second conditional store to the same address fails.
- R8: A high `exc_in` invalidates the reservation.
- R9: Plain stores leave the reservation in place. A conditional store after a plain store that rewrote the same value passes; one after a plain store that changed the word fails.
- R10: After reset, `done`, `flag`, `busy` and `mem_req` are 0, `cmd_ready` is 1, and no reservation is valid.
- R11: A new reserving load replaces any earlier reservation.
- R12: Address 0xFFFFFFFC can be reserved and stored to conditionally like any other. Without a live reservation, a conditional store to 0xFFFFFFFC or 0xFFFFFFFF fails.
- R13: Only one command is in flight. `busy` is high and `cmd_ready` is low from acceptance until `done`. A memory request holds its address until it is served. `flag` holds its value through plain operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle, command taken on this edge |
| cmd_opc | input | 6 | Major opcode |
| cmd_base | input | 32 | Base register value |
| cmd_ofs | input | 16 | Signed offset |
| cmd_wdata | input | 32 | Store data |
| exc_in | input | 1 | Exception or interrupt taken; drops the reservation |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Word returned by the last load |
| flag | output | 1 | Result of the last conditional store |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request served this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
Conditional stores are tried in four situations:
- With no reservation, to show the early fail with no memory access.
- After a reserving load to a different address, to separate a wrong address from a stale value.
- After a plain store that either rewrote the same value or changed it, or after another memory master changed the word, to show that the re-read value and not the store itself decides the outcome.
- After an exception.

Latencies are measured with zero and two memory wait cycles, so that the single-access path and the read-then-write path are told apart by cycle count. The all-ones address region is used both with and without a live reservation, to separate the valid bit from the parked marker.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  localparam int unsigned OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_LDRES  = 6'h1b;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h21;
  localparam logic [OPC_W-1:0] OPC_STCOND = 6'h33;
  localparam logic [OPC_W-1:0] OPC_STORE  = 6'h35;

  typedef enum logic [2:0] {
    K_NONE, K_LOAD, K_LDRES, K_STORE, K_STCOND
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WRITE, S_CHECK, S_CWRITE
  } state_e;
endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
  import lrsc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFSW = 16
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [XLEN-1:0]  base,
  input  logic [OFSW-1:0]  ofs,
  output kind_e            kind,
  output logic [XLEN-1:0]  ea
);
  localparam int EXTW = XLEN - OFSW;

  logic [XLEN-1:0] ofs_x;

  // sign extension of the offset
  assign ofs_x = {{EXTW{ofs[OFSW-1]}}, ofs};
  assign ea    = base + ofs_x;

  always_comb begin
    unique case (opc)
      OPC_LDRES:  kind = K_LDRES;
      OPC_LOAD:   kind = K_LOAD;
      OPC_STORE:  kind = K_STORE;
      OPC_STCOND: kind = K_STCOND;
      default:    kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic [XLEN-1:0] set_addr,
  input  logic [XLEN-1:0] set_val,
  input  logic            clr,
  input  logic            exc,
  input  logic [XLEN-1:0] probe_addr,
  output logic            hit,
  output logic            valid,
  output logic [XLEN-1:0] val
);
  localparam logic [XLEN-1:0] PARK = '1;

  logic [XLEN-1:0] addr_q;

  // invalidation wins over a reservation set in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      addr_q <= PARK;
      val    <= '0;
    end else if (exc || clr) begin
      valid  <= 1'b0;
      addr_q <= PARK;
    end else if (set) begin
      valid  <= 1'b1;
      addr_q <= set_addr;
      val    <= set_val;
    end
  end

  assign hit = valid && (addr_q == probe_addr);
endmodule

// File: rtl/lrsc_seq.sv
module lrsc_seq
  import lrsc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  kind_e           kind,
  input  logic [XLEN-1:0] ea,
  input  logic [XLEN-1:0] wdata,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] rdata,
  output logic            flag,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            resv_hit,
  input  logic            resv_valid,
  input  logic [XLEN-1:0] resv_val,
  output logic            resv_set,
  output logic            resv_clr
);
  state_e          state;
  kind_e           kind_q;
  logic [XLEN-1:0] ea_q;
  logic [XLEN-1:0] wd_q;
  logic            accept;
  logic            still_same;
  logic            early_fail;

  assign cmd_ready  = (state == S_IDLE);
  assign busy       = (state != S_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign early_fail = accept && (kind == K_STCOND) && !resv_hit;
  assign still_same = resv_valid && (mem_rdata == resv_val);

  assign mem_req   = (state == S_READ) || (state == S_WRITE) ||
                     (state == S_CHECK) || (state == S_CWRITE);
  assign mem_we    = (state == S_WRITE) || (state == S_CWRITE);
  assign mem_addr  = ea_q;
  assign mem_wdata = wd_q;

  assign resv_set = (state == S_READ) && mem_ready && (kind_q == K_LDRES);
  assign resv_clr = early_fail ||
                    ((state == S_CHECK) && mem_ready && !still_same) ||
                    ((state == S_CWRITE) && mem_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      kind_q <= K_NONE;
      ea_q   <= '0;
      wd_q   <= '0;
      done   <= 1'b0;
      rdata  <= '0;
      flag   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            kind_q <= kind;
            ea_q   <= ea;
            wd_q   <= wdata;
            unique case (kind)
              K_LOAD, K_LDRES: state <= S_READ;
              K_STORE:         state <= S_WRITE;
              K_STCOND: begin
                if (resv_hit) begin
                  state <= S_CHECK;
                end else begin
                  done <= 1'b1;
                  flag <= 1'b0;
                end
              end
              default: done <= 1'b1;
            endcase
          end
        end
        S_READ: begin
          if (mem_ready) begin
            rdata <= mem_rdata;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_WRITE: begin
          if (mem_ready) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_CHECK: begin
          if (mem_ready) begin
            if (still_same) begin
              state <= S_CWRITE;
            end else begin
              done  <= 1'b1;
              flag  <= 1'b0;
              state <= S_IDLE;
            end
          end
        end
        S_CWRITE: begin
          if (mem_ready) begin
            done  <= 1'b1;
            flag  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
  import lrsc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFSW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [OPC_W-1:0] cmd_opc,
  input  logic [XLEN-1:0]  cmd_base,
  input  logic [OFSW-1:0]  cmd_ofs,
  input  logic [XLEN-1:0]  cmd_wdata,
  input  logic             exc_in,
  output logic             busy,
  output logic             done,
  output logic [XLEN-1:0]  rdata,
  output logic             flag,
  output logic             mem_req,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic             mem_ready,
  input  logic [XLEN-1:0]  mem_rdata
);
  kind_e           kind;
  logic [XLEN-1:0] ea;
  logic            resv_hit;
  logic            resv_valid;
  logic [XLEN-1:0] resv_val;
  logic            resv_set;
  logic            resv_clr;

  lrsc_decode #(.XLEN(XLEN), .OFSW(OFSW)) u_dec (
    .opc(cmd_opc), .base(cmd_base), .ofs(cmd_ofs), .kind(kind), .ea(ea)
  );

  lrsc_resv #(.XLEN(XLEN)) u_resv (
    .clk(clk), .rst_n(rst_n),
    .set(resv_set), .set_addr(mem_addr), .set_val(mem_rdata),
    .clr(resv_clr), .exc(exc_in), .probe_addr(ea),
    .hit(resv_hit), .valid(resv_valid), .val(resv_val)
  );

  lrsc_seq #(.XLEN(XLEN)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .kind(kind), .ea(ea), .wdata(cmd_wdata),
    .busy(busy), .done(done), .rdata(rdata), .flag(flag),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .resv_hit(resv_hit), .resv_valid(resv_valid), .resv_val(resv_val),
    .resv_set(resv_set), .resv_clr(resv_clr)
  );
endmodule

// File: rtl/lrsc_chk.sv
module lrsc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            flag,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ready,
  input logic [XLEN-1:0] mem_addr,
  input logic            exc_in,
  input logic            resv_valid
);
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R13

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R13

  AST_FLAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flag) |-> done); // R6

  AST_FLAG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(mem_req && mem_we && mem_ready)); // R6

  AST_EXC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    exc_in |=> !resv_valid); // R8
endmodule

bind lrsc_unit lrsc_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .flag(flag),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .exc_in(exc_in), .resv_valid(resv_valid)
);

// File: tb/sim_lrsc_unit.sv
`timescale 1ns/1ps
module sim_lrsc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [5:0]  cmd_opc = '0;
  logic [31:0] cmd_base = '0;
  logic [15:0] cmd_ofs = '0;
  logic [31:0] cmd_wdata = '0;
  logic        exc_in = 1'b0;
  logic        busy, done, flag, mem_req, mem_we, mem_ready;
  logic [31:0] rdata, mem_addr, mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  lrsc_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_opc(cmd_opc), .cmd_base(cmd_base), .cmd_ofs(cmd_ofs),
    .cmd_wdata(cmd_wdata), .exc_in(exc_in), .busy(busy), .done(done),
    .rdata(rdata), .flag(flag), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata)
  );

  // behavioural memory with programmable wait cycles
  logic [31:0] mem [64];
  int          wait_cyc = 0;
  int          wcnt = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  logic [31:0] last_addr = '0;

  assign mem_ready = mem_req && (wcnt == wait_cyc);
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_req && mem_ready) begin
      last_addr <= mem_addr;
      if (mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  bit          m_ok = 1'b0;
  logic [31:0] m_addr = '1;
  logic [31:0] m_val = '0;
  bit          m_flag = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [5:0] opc, input logic [31:0] base,
                        input logic [15:0] ofs, input logic [31:0] wd,
                        input string rq);
    logic [31:0] ea;
    logic [31:0] exp_rd;
    int          idx, exp_k, rd_d, wr_d, k, rd0, wr0;
    bit          is_load, does_write;
    ea = base + {{16{ofs[15]}}, ofs};
    idx = int'(ea[7:2]);
    exp_rd = mem[idx];
    is_load = 1'b0; does_write = 1'b0; rd_d = 0; wr_d = 0; exp_k = 0;
    case (opc)
      6'h1b: begin
        exp_k = wait_cyc + 1; rd_d = 1; is_load = 1'b1;
        m_ok = 1'b1; m_addr = ea; m_val = exp_rd;
      end
      6'h21: begin exp_k = wait_cyc + 1; rd_d = 1; is_load = 1'b1; end
      6'h35: begin exp_k = wait_cyc + 1; wr_d = 1; does_write = 1'b1; end
      6'h33: begin
        if (!(m_ok && ea == m_addr)) begin
          exp_k = 0; m_flag = 1'b0;
        end else if (mem[idx] != m_val) begin
          exp_k = wait_cyc + 1; rd_d = 1; m_flag = 1'b0;
        end else begin
          exp_k = 2 * wait_cyc + 2; rd_d = 1; wr_d = 1; does_write = 1'b1;
          m_flag = 1'b1;
        end
        m_ok = 1'b0;
      end
      default: exp_k = 0;
    endcase
    rd0 = rd_cnt; wr0 = wr_cnt;
    chk(cmd_ready == 1'b1, "R13", "ready before command", {31'b0, cmd_ready}, 32'h1);
    cmd_valid = 1'b1; cmd_opc = opc; cmd_base = base; cmd_ofs = ofs; cmd_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    k = 0;
    while (!done && k < 100) begin
      chk(busy && !cmd_ready, "R13", "busy and not ready in flight",
          {30'b0, busy, cmd_ready}, 32'h2);
      @(negedge clk);
      k++;
    end
    chk(k == exp_k, rq, "done latency", k, exp_k);
    chk(!busy, "R13", "idle at done", {31'b0, busy}, 32'h0);
    chk(flag == m_flag, rq, "flag", {31'b0, flag}, {31'b0, m_flag});
    if (is_load) chk(rdata == exp_rd, rq, "load data", rdata, exp_rd);
    if (does_write) chk(mem[idx] == wd, rq, "memory word after write", mem[idx], wd);
    chk(rd_cnt - rd0 == rd_d, rq, "memory reads", rd_cnt - rd0, rd_d);
    chk(wr_cnt - wr0 == wr_d, rq, "memory writes", wr_cnt - wr0, wr_d);
    if (rd_d + wr_d > 0) chk(last_addr == ea, "R1", "effective address", last_addr, ea);
    @(negedge clk);
  endtask

  task automatic take_exc();
    exc_in = 1'b1;
    @(negedge clk);
    exc_in = 1'b0;
    m_ok = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
    repeat (3) @(negedge clk);
    chk(!done && !flag && !busy && !mem_req && cmd_ready, "R10", "reset outputs",
        {27'b0, done, flag, busy, mem_req, cmd_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    wait_cyc = 0;
    run_op(6'h33, 32'h10, 16'h0, 32'h1111_1111, "R10");   // no reservation after reset
    run_op(6'h1b, 32'h20, 16'hFFFC, 32'h0, "R2");          // reserve 0x1C via negative offset
    run_op(6'h33, 32'h18, 16'h0004, 32'hCAFE_0001, "R6");  // success
    run_op(6'h33, 32'h1C, 16'h0, 32'hDEAD_0002, "R7");     // reservation gone
    run_op(6'h21, 32'h40, 16'h0, 32'h0, "R2");             // plain load does not reserve
    run_op(6'h33, 32'h40, 16'h0, 32'h1234_5678, "R4");

    wait_cyc = 2;
    run_op(6'h1b, 32'h30, 16'h0, 32'h0, "R2");
    run_op(6'h35, 32'h30, 16'h0, 32'h5555_AAAA, "R3");     // changes the word
    run_op(6'h33, 32'h30, 16'h0, 32'h7777_0000, "R5");     // value differs: fail
    chk(mem[12] == 32'h5555_AAAA, "R9", "word kept by failed store", mem[12], 32'h5555_AAAA);
    run_op(6'h1b, 32'h30, 16'h0, 32'h0, "R9");
    run_op(6'h35, 32'h30, 16'h0, 32'h5555_AAAA, "R9");     // same value rewritten
    run_op(6'h33, 32'h30, 16'h0, 32'h7777_0001, "R9");     // still passes
    run_op(6'h21, 32'h40, 16'h0, 32'h0, "R13");            // flag must hold at 1
    run_op(6'h1b, 32'h50, 16'h0, 32'h0, "R2");
    mem[20] = 32'h0BAD_F00D;                               // another master changes it
    run_op(6'h33, 32'h50, 16'h0, 32'h1, "R5");
    run_op(6'h1b, 32'h60, 16'h0, 32'h0, "R2");
    take_exc();
    run_op(6'h33, 32'h60, 16'h0, 32'h2, "R8");
    run_op(6'h1b, 32'h60, 16'h0, 32'h0, "R11");
    run_op(6'h1b, 32'h64, 16'h0, 32'h0, "R11");
    run_op(6'h33, 32'h60, 16'h0, 32'h3, "R11");            // old reservation replaced
    run_op(6'h1b, 32'h64, 16'h0, 32'h0, "R11");
    run_op(6'h33, 32'h64, 16'h0, 32'h4, "R11");            // newest one passes
    run_op(6'h33, 32'hFFFF_FFFC, 16'h0, 32'h5, "R12");
    run_op(6'h33, 32'hFFFF_FFFF, 16'h0, 32'h6, "R12");
    run_op(6'h1b, 32'h0, 16'hFFFC, 32'h0, "R12");
    run_op(6'h33, 32'hFFFF_FFF8, 16'h0004, 32'h7, "R12");
    run_op(6'h33, 32'hFFFF_FFFC, 16'h0, 32'h8, "R12");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule